// File: doc/BRIEF.md
# MDIO Management Frame Target

This block is the target side of a two-wire serial management bus. It runs on the system clock, oversamples the management clock (MDC) and data (MDIO) lines, and decodes clause-22 style frames. Each frame is a run of ones for the preamble, a start pattern, an opcode, a PHY address, a register address, a two-bit turnaround and a 16-bit data field. Every field is sent most significant bit first.

The block answers to one PHY address, which is strapped on an input pin. For a write it hands the register address and the assembled data to a register file through a one-cycle write strobe. For a read it loads the value on the read-data port and shifts it onto MDIO, together with an output enable for an external tri-state pad. A read aimed at any other address leaves the line released, so the bus pull-up returns all ones to the host.

Top module: `mdio_slave`

## Requirements
- R1: After reset, mdio_oe_o and reg_we_o are low and mdio_o is high.
- R2: A frame is recognised only after at least 32 consecutive ones, sampled on MDC rising edges, followed by a zero. A zero that comes after fewer ones discards the frame that follows.
- R3: The bit after that zero must be a one, which completes the start pattern 01. A zero in that position abandons the frame and the block goes back to counting preamble.
- R4: After the start pattern the block shifts in the opcode (2 bits), the PHY address (5 bits) and the register address (5 bits), each MSB first on MDC rising edges. The captured register address appears on reg_addr_o.
- R5: For opcode 10 (read) addressed to phy_addr_i, the 16-bit value on reg_rdata_i, sampled at the second turnaround bit, is driven MSB first. Each bit is changed only after an MDC falling edge, so it is stable at the following rising edge.
- R6: mdio_oe_o is high only during the 16 data bits of a read addressed to phy_addr_i. It is never high during the preamble, the header or the turnaround, and never at the same time as reg_we_o.
- R7: A read to any other PHY address never raises mdio_oe_o, so the host reads 0xFFFF.
- R8: For opcode 01 (write) addressed to phy_addr_i, reg_we_o pulses for exactly one clock, with the 16 data bits on reg_wdata_o. The pulse comes only after the 16th data bit has been sampled.
- R9: A write to any other PHY address produces no strobe and leaves the register contents unchanged.
- R10: Opcodes 00 and 11 are run through to the end of the frame with no strobe and no drive.
- R11: After the 16th data bit the block releases MDIO and goes back to hunting for a preamble. A frame that follows without a new preamble is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than MDC |
| rst_ni | input | 1 | Active-low asynchronous reset |
| phy_addr_i | input | 5 | Strapped PHY address this target answers to |
| mdc_i | input | 1 | Management clock from the bus |
| mdio_i | input | 1 | Resolved management data line |
| mdio_o | output | 1 | Data driven during a read |
| mdio_oe_o | output | 1 | Output enable for the MDIO pad |
| reg_addr_o | output | 5 | Register address captured from the frame |
| reg_rdata_i | input | 16 | Read data from the register file |
| reg_wdata_o | output | 16 | Write data to the register file |
| reg_we_o | output | 1 | One-cycle write strobe |

## Verification
Because every field is position-coded, a wrong internal state shows up at the ports as a fault in the same frame. A header shifted by one bit puts the wrong reg_addr_o into the next strobe. A wrong preamble or start count produces a strobe that should not happen, or drops one, within a few system clocks of the 16th data bit. A wrong output-enable state is visible within one MDC half period, because the bench compares the enable and the resolved line on every bit against its behavioural model. The bench also flags any strobe or drive that falls outside an expected window on every clock.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [2:0] {
    ST_HUNT, ST_START, ST_OPC, ST_PHY, ST_REG, ST_TA, ST_DATA
  } mdio_state_e;

  localparam logic [1:0] OPC_WR = 2'b01;
  localparam logic [1:0] OPC_RD = 2'b10;
endpackage

// File: rtl/mdio_in_sync.sv
module mdio_in_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= {STAGES{RST_VAL[g]}};
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/mdio_edge_det.sv
module mdio_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end
  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/mdio_frame_dec.sv
module mdio_frame_dec
  import mdio_pkg::*;
#(
  parameter int unsigned ADDR_W  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned PRE_LEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              bit_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              mdio_o,
  output logic              oe_o,
  output logic [ADDR_W-1:0] phy_o,
  output logic [1:0]        opc_o
);
  localparam int unsigned CNT_W = $clog2(DATA_W);
  localparam int unsigned PRE_W = $clog2(PRE_LEN + 1);

  mdio_state_e       state_q;
  logic [PRE_W-1:0]  pre_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [1:0]        opc_q;
  logic [ADDR_W-1:0] phy_q, reg_q;
  logic [DATA_W-1:0] rsh_q, wsh_q, wdata_q;
  logic              act_rd_q, act_wr_q, we_q, dout_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_HUNT;
      pre_q    <= '0;
      cnt_q    <= '0;
      opc_q    <= '0;
      phy_q    <= '0;
      reg_q    <= '0;
      rsh_q    <= '1;
      wsh_q    <= '0;
      wdata_q  <= '0;
      act_rd_q <= 1'b0;
      act_wr_q <= 1'b0;
      we_q     <= 1'b0;
      dout_q   <= 1'b1;
      oe_q     <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (rise_i) begin
        unique case (state_q)
          ST_HUNT: begin
            if (bit_i) begin
              if (pre_q != PRE_W'(PRE_LEN)) pre_q <= pre_q + 1'b1;
            end else begin
              if (pre_q == PRE_W'(PRE_LEN)) state_q <= ST_START;
              pre_q <= '0;
            end
          end
          ST_START: begin
            state_q <= bit_i ? ST_OPC : ST_HUNT;
            cnt_q   <= '0;
          end
          ST_OPC: begin
            opc_q <= {opc_q[0], bit_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              state_q <= ST_PHY;
              cnt_q   <= '0;
            end
          end
          ST_PHY: begin
            phy_q <= {phy_q[ADDR_W-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              state_q <= ST_REG;
              cnt_q   <= '0;
            end
          end
          ST_REG: begin
            reg_q <= {reg_q[ADDR_W-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(ADDR_W - 1)) begin
              state_q <= ST_TA;
              cnt_q   <= '0;
            end
          end
          ST_TA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(1)) begin
              state_q  <= ST_DATA;
              cnt_q    <= '0;
              rsh_q    <= rdata_i;
              act_rd_q <= (opc_q == OPC_RD) && (phy_q == phy_addr_i);
              act_wr_q <= (opc_q == OPC_WR) && (phy_q == phy_addr_i);
            end
          end
          ST_DATA: begin
            wsh_q <= {wsh_q[DATA_W-2:0], bit_i};
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              state_q  <= ST_HUNT;
              cnt_q    <= '0;
              oe_q     <= 1'b0;
              dout_q   <= 1'b1;
              act_rd_q <= 1'b0;
              act_wr_q <= 1'b0;
              if (act_wr_q) begin
                we_q    <= 1'b1;
                wdata_q <= {wsh_q[DATA_W-2:0], bit_i};
              end
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end else if (fall_i && state_q == ST_DATA && act_rd_q) begin
        // update while MDC is low so the bit is settled at the next rise
        oe_q   <= 1'b1;
        dout_q <= rsh_q[DATA_W-1];
        rsh_q  <= {rsh_q[DATA_W-2:0], 1'b1};
      end
    end
  end

  assign reg_addr_o = reg_q;
  assign wdata_o    = wdata_q;
  assign we_o       = we_q;
  assign mdio_o     = dout_q;
  assign oe_o       = oe_q;
  assign phy_o      = phy_q;
  assign opc_o      = opc_q;
endmodule

// File: rtl/mdio_slave.sv
module mdio_slave #(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned PRE_LEN     = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic              mdc_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic [DATA_W-1:0] reg_wdata_o,
  output logic              reg_we_o
);
  logic [1:0]        sync_q;
  logic              mdc_rise, mdc_fall;
  logic [ADDR_W-1:0] phy_cap;
  logic [1:0]        opc_cap;

  mdio_in_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mdio_i, mdc_i}),
    .q_o   (sync_q)
  );

  mdio_edge_det u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (sync_q[0]),
    .rise_o(mdc_rise),
    .fall_o(mdc_fall)
  );

  mdio_frame_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRE_LEN(PRE_LEN)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (mdc_rise),
    .fall_i    (mdc_fall),
    .bit_i     (sync_q[1]),
    .phy_addr_i(phy_addr_i),
    .rdata_i   (reg_rdata_i),
    .reg_addr_o(reg_addr_o),
    .wdata_o   (reg_wdata_o),
    .we_o      (reg_we_o),
    .mdio_o    (mdio_o),
    .oe_o      (mdio_oe_o),
    .phy_o     (phy_cap),
    .opc_o     (opc_cap)
  );
endmodule

// File: rtl/mdio_slave_chk.sv
module mdio_slave_chk #(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              mdc_rise,
  input logic              mdc_fall,
  input logic              mdio_o,
  input logic              mdio_oe_o,
  input logic              reg_we_o,
  input logic [ADDR_W-1:0] phy_addr_i,
  input logic [ADDR_W-1:0] phy_cap,
  input logic [1:0]        opc_cap
);
  p_we_single_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  p_we_opcode_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> opc_cap == 2'b01);

  p_we_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> phy_cap == phy_addr_i);

  p_oe_target_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_oe_o |-> (phy_cap == phy_addr_i && opc_cap == 2'b10));

  p_oe_after_fall_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdio_oe_o) |-> $past(mdc_fall));

  p_oe_we_excl_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mdio_oe_o && reg_we_o));

  p_hold_at_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_rise && mdio_oe_o) |=> ($stable(mdio_o) || !mdio_oe_o));
endmodule

bind mdio_slave mdio_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_rise  (mdc_rise),
  .mdc_fall  (mdc_fall),
  .mdio_o    (mdio_o),
  .mdio_oe_o (mdio_oe_o),
  .reg_we_o  (reg_we_o),
  .phy_addr_i(phy_addr_i),
  .phy_cap   (phy_cap),
  .opc_cap   (opc_cap)
);

// File: tb/mdio_slave_tb_top.sv
module mdio_slave_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic mdc = 1'b0, mst = 1'b1;
  logic [4:0] strap = 5'h05;
  logic mdio_o, oe, we;
  logic [4:0] raddr;
  logic [15:0] rdata, wdata;
  wire line = oe ? mdio_o : mst;   // pull-up when nobody drives

  logic [15:0] rf [32];
  logic [15:0] ref_mem [32];
  assign rdata = rf[raddr];

  mdio_slave dut_i (
    .clk_i(clk), .rst_ni(rst_n), .phy_addr_i(strap), .mdc_i(mdc), .mdio_i(line),
    .mdio_o(mdio_o), .mdio_oe_o(oe), .reg_addr_o(raddr), .reg_rdata_i(rdata),
    .reg_wdata_o(wdata), .reg_we_o(we)
  );

  int errors = 0, checks = 0, we_cnt = 0, cyc = 0;
  logic [4:0] last_addr = '0;
  logic [15:0] last_data = '0;
  logic we_window = 1'b0, oe_window = 1'b0, done = 1'b0;

  function automatic logic [15:0] init_val(int i);
    return 16'(i * 16'h0405) ^ 16'h3C00;
  endfunction

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) rf[i] <= init_val(i);
    end else if (we) begin
      we_cnt++;
      last_addr <= raddr;
      last_data <= wdata;
      rf[raddr] <= wdata;
    end
    if (cyc > 150000 && !done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=%0d expected<=150000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock model comparison: strobe and drive only inside expected windows
  always @(negedge clk) begin
    if (rst_n && we) chk(we_window, "R8 strobe window", {31'd0, we}, 32'd0);
    if (rst_n && oe) chk(oe_window, "R6 drive window", {31'd0, oe}, 32'd0);
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_cycle(input logic b, output logic smp, output logic oe_s);
    mdc = 1'b0; mst = b;
    tick(HALF);
    smp = line; oe_s = oe;
    mdc = 1'b1;
    tick(HALF);
  endtask

  task automatic run_frame(input int npre, input logic [1:0] st, input logic [1:0] opc,
                           input logic [4:0] phy, input logic [4:0] rg, input logic [15:0] wd,
                           input bit act, output logic [15:0] rd, output int oe_data,
                           output int oe_other, output int we_mid, output int we_start);
    logic s, o;
    logic [15:0] hdr;
    oe_data = 0; oe_other = 0;
    hdr = {st, opc, phy, rg, 2'b00};
    for (int i = 0; i < npre; i++) begin bit_cycle(1'b1, s, o); oe_other += int'(o); end
    for (int i = 15; i >= 2; i--) begin bit_cycle(hdr[i], s, o); oe_other += int'(o); end
    bit_cycle(1'b1, s, o); oe_other += int'(o);
    bit_cycle((opc == 2'b10) ? 1'b1 : 1'b0, s, o); oe_other += int'(o);
    oe_window = act && (opc == 2'b10);
    we_start = we_cnt;
    for (int i = 15; i >= 0; i--) begin
      if (i == 0) begin
        we_mid = we_cnt;
        we_window = act && (opc == 2'b01);
      end
      bit_cycle((opc == 2'b10) ? 1'b1 : wd[i], s, o);
      rd[i] = s;
      oe_data += int'(o);
    end
    oe_window = 1'b0;
    tick(2);
    we_window = 1'b0;
  endtask

  logic [15:0] rd;
  int od, oo, wm, ws;

  task automatic do_write(input int npre, input logic [1:0] st, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] d, input bit act);
    run_frame(npre, st, 2'b01, phy, rg, d, act, rd, od, oo, wm, ws);
    if (act) ref_mem[rg] = d;
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] rg, input bit act);
    run_frame(32, 2'b01, 2'b10, phy, rg, 16'h0, act, rd, od, oo, wm, ws);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) ref_mem[i] = init_val(i);
    tick(5);
    chk(oe == 1'b0, "R1 oe after reset", {31'd0, oe}, 32'd0);
    chk(we == 1'b0, "R1 we after reset", {31'd0, we}, 32'd0);
    chk(mdio_o == 1'b1, "R1 mdio_o after reset", {31'd0, mdio_o}, 32'd1);
    rst_n = 1'b1;
    tick(4);

    // matching write
    do_write(32, 2'b01, strap, 5'd3, 16'hA5C3, 1'b1);
    chk(we_cnt == ws + 1, "R8 one strobe", we_cnt, ws + 1);
    chk(wm == ws, "R8 no strobe before 16th bit", wm, ws);
    chk(last_addr == 5'd3, "R4 write address", {27'd0, last_addr}, 32'd3);
    chk(last_data == 16'hA5C3, "R8 write data", {16'd0, last_data}, 32'hA5C3);
    chk(od == 0 && oo == 0, "R6 no drive on write", od + oo, 0);

    // matching read back
    do_read(strap, 5'd3, 1'b1);
    chk(rd == ref_mem[3], "R5 read data MSB first", {16'd0, rd}, {16'd0, ref_mem[3]});
    chk(od == 16, "R6 oe during all data bits", od, 16);
    chk(oo == 0, "R6 oe off outside data", oo, 0);
    chk(oe == 1'b0, "R11 line released after frame", {31'd0, oe}, 32'd0);

    do_read(strap, 5'd17, 1'b1);
    chk(rd == ref_mem[17], "R4 register address decode", {16'd0, rd}, {16'd0, ref_mem[17]});

    // other PHY address
    do_read(5'h06, 5'd3, 1'b0);
    chk(rd == 16'hFFFF, "R7 foreign read all ones", {16'd0, rd}, 32'hFFFF);
    chk(od == 0, "R7 no drive on foreign read", od, 0);

    do_write(32, 2'b01, 5'h1A, 5'd3, 16'h1234, 1'b0);
    chk(we_cnt == ws, "R9 foreign write no strobe", we_cnt, ws);
    do_read(strap, 5'd3, 1'b1);
    chk(rd == ref_mem[3], "R9 register unchanged", {16'd0, rd}, {16'd0, ref_mem[3]});

    // unused opcodes
    run_frame(32, 2'b01, 2'b00, strap, 5'd3, 16'h5555, 1'b0, rd, od, oo, wm, ws);
    chk(we_cnt == ws && od == 0, "R10 opcode 00 ignored", we_cnt + od, ws);
    run_frame(32, 2'b01, 2'b11, strap, 5'd3, 16'h0F0F, 1'b0, rd, od, oo, wm, ws);
    chk(we_cnt == ws && od == 0, "R10 opcode 11 ignored", we_cnt + od, ws);

    // short preamble
    do_write(31, 2'b01, strap, 5'd4, 16'hBEEF, 1'b0);
    chk(we_cnt == ws, "R2 31-bit preamble rejected", we_cnt, ws);
    do_read(strap, 5'd4, 1'b1);
    chk(rd == ref_mem[4], "R2 register intact", {16'd0, rd}, {16'd0, ref_mem[4]});
    do_write(40, 2'b01, strap, 5'd4, 16'h0F0E, 1'b1);
    chk(we_cnt == ws + 1 && last_data == 16'h0F0E, "R2 long preamble accepted", {16'd0, last_data}, 32'h0F0E);

    // bad start pattern
    do_write(32, 2'b00, strap, 5'd5, 16'h7777, 1'b0);
    chk(we_cnt == ws, "R3 bad start abandoned", we_cnt, ws);
    do_read(strap, 5'd5, 1'b1);
    chk(rd == ref_mem[5], "R3 register intact", {16'd0, rd}, {16'd0, ref_mem[5]});

    // back-to-back frame without preamble
    do_write(0, 2'b01, strap, 5'd6, 16'h6666, 1'b0);
    chk(we_cnt == ws, "R11 no preamble ignored", we_cnt, ws);

    // new strap value
    strap = 5'h12;
    tick(4);
    do_write(32, 2'b01, 5'h12, 5'd7, 16'h8001, 1'b1);
    chk(we_cnt == ws + 1 && last_addr == 5'd7, "R4 write under new strap", {27'd0, last_addr}, 32'd7);
    do_read(5'h05, 5'd7, 1'b0);
    chk(rd == 16'hFFFF, "R7 old address now foreign", {16'd0, rd}, 32'hFFFF);
    do_read(5'h12, 5'd7, 1'b1);
    chk(rd == 16'h8001, "R5 edge bits in order", {16'd0, rd}, 32'h8001);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule